// File: doc/BRIEF.md
# Keyed External Reset Pulse Generator

This block turns a single trigger event from a watchdog into a reset pulse on an external pin. The pulse length is counted in microsecond ticks supplied from outside, and both the electrical behaviour of the pin and its active level are programmable. Everything is held in one 32-bit configuration word that is accessed with a write strobe and a read strobe.

The low 20 bits hold a duration value N. A pulse lasts N+1 ticks. Every write updates this value. The two flags that set polarity and drive mode change only when the top byte of the written word carries one of four key values. Any other top byte leaves both flags as they were. This keeps a stray or partial write from turning an open-drain, active-low reset line into a driven high.

Control is a three-state machine. In `ST_IDLE` the pin is deasserted. A trigger takes the *arm* transition to `ST_ALIGN` and latches N. The next tick takes the *launch* transition to `ST_DRIVE`, where the pin is asserted. Each later tick counts the latched value down. The tick that finds the count at zero takes the *expire* transition back to `ST_IDLE`. Triggers seen in `ST_ALIGN` or `ST_DRIVE` are dropped. The pin is presented as an output level `pad_out` and an output enable `pad_oe`.

Top module: `ext_reset_pulser`

## Requirements
- R1: After reset the word reads 0x000000FF: duration 255, bit 31 = 0 (active-low), bit 30 = 0 (open-drain).
- R2: A trigger arms the block. The pin asserts at the first tick after the trigger and stays asserted for exactly N+1 tick periods, so N = 0 gives one tick period.
- R3: A write whose top byte is 0xA5 sets bit 31 (active-high). A top byte of 0x5A clears it (active-low).
- R4: A write whose top byte is 0xA8 sets bit 30 (push-pull). A top byte of 0x8A clears it (open-drain).
- R5: A write with any other top byte leaves bits 31 and 30 unchanged. Bits [19:0] are still loaded from the written value on every write.
- R6: In push-pull mode `pad_oe` is always 1. `pad_out` equals the asserted level while a pulse runs and its inverse otherwise.
- R7: In open-drain mode `pad_out` is 0. `pad_oe` is 1 only while the line should be low: during a pulse when active-low, or outside a pulse when active-high.
- R8: A trigger that arrives while a pulse is armed or running is ignored. No second pulse follows.
- R9: The duration is latched at the trigger. A write during a pulse does not change the length of that pulse.
- R10: Bits [29:20] always read as zero. `rd_data` is zero when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe once per microsecond |
| trig | input | 1 | Reset request from the watchdog, one cycle |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Configuration word while `rd_en` is high, else zero |
| pad_out | output | 1 | Level driven onto the pin |
| pad_oe | output | 1 | Output enable for the pin |

## Verification
The hardest cases to reach from the ports arise when events overlap with a pulse. A trigger must be repeated while the machine waits in `ST_ALIGN` and again inside `ST_DRIVE`. A new duration must be written in the middle of a pulse. The stimulus fires the trigger and then, on the very next cycles, a second trigger and a short-duration write, all before the pulse ends. The scoreboard then expects a single pulse of the original length followed by a quiet pin. Each polarity and drive combination is walked through by key writes, and a non-key top byte follows every mode change.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_DRIVE = 2'd2
    } pulse_state_e;

    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_PUSHPULL = 8'hA8;
    localparam logic [7:0] KEY_OPENDRN  = 8'h8A;

endpackage

// File: rtl/rpg_cfg_reg.sv
module rpg_cfg_reg
    import rpg_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DUR_W   = 20,
    parameter int DUR_RST = 'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DUR_W-1:0]  dur,
    output logic              pol_high,
    output logic              push_pull
);
    localparam int KEY_LSB = DATA_W - 8;

    logic [7:0] key_byte;
    assign key_byte = wr_data[DATA_W-1:KEY_LSB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dur       <= DUR_W'(DUR_RST);
            pol_high  <= 1'b0;
            push_pull <= 1'b0;
        end else if (wr_en) begin
            dur <= wr_data[DUR_W-1:0];
            unique case (key_byte)
                KEY_POL_HIGH: pol_high  <= 1'b1;
                KEY_POL_LOW:  pol_high  <= 1'b0;
                KEY_PUSHPULL: push_pull <= 1'b1;
                KEY_OPENDRN:  push_pull <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rpg_pulse_fsm.sv
module rpg_pulse_fsm
    import rpg_pkg::*;
#(
    parameter int DUR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trig,
    input  logic [DUR_W-1:0] dur,
    output logic             active
);
    pulse_state_e state_q, state_d;
    logic [DUR_W-1:0] cnt_q;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (trig) state_d = ST_ALIGN;
            ST_ALIGN: if (tick) state_d = ST_DRIVE;
            ST_DRIVE: if (tick && cnt_zero) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && trig) begin
                cnt_q <= dur;
            end else if (state_q == ST_DRIVE && tick && !cnt_zero) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        active = (state_q == ST_DRIVE);
    end
endmodule

// File: rtl/rpg_pin_drive.sv
module rpg_pin_drive (
    input  logic active,
    input  logic pol_high,
    input  logic push_pull,
    output logic pad_out,
    output logic pad_oe
);
    logic line_level;

    assign line_level = pol_high ? active : !active;

    always_comb begin
        if (push_pull) begin
            pad_oe  = 1'b1;
            pad_out = line_level;
        end else begin
            pad_oe  = !line_level;
            pad_out = 1'b0;
        end
    end
endmodule

// File: rtl/ext_reset_pulser.sv
module ext_reset_pulser #(
    parameter int DATA_W  = 32,
    parameter int DUR_W   = 20,
    parameter int DUR_RST = 'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              trig,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              pad_out,
    output logic              pad_oe
);
    localparam int GAP_W = DATA_W - 2 - DUR_W;

    logic [DUR_W-1:0] dur;
    logic             pol_high;
    logic             push_pull;
    logic             pulse_active;

    rpg_cfg_reg #(.DATA_W(DATA_W), .DUR_W(DUR_W), .DUR_RST(DUR_RST)) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .dur(dur), .pol_high(pol_high), .push_pull(push_pull)
    );

    rpg_pulse_fsm #(.DUR_W(DUR_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig),
        .dur(dur), .active(pulse_active)
    );

    rpg_pin_drive i_pin (
        .active(pulse_active), .pol_high(pol_high), .push_pull(push_pull),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    assign rd_data = rd_en ? {pol_high, push_pull, {GAP_W{1'b0}}, dur} : '0;
endmodule

// File: rtl/ext_reset_pulser_chk.sv
module ext_reset_pulser_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              pad_out,
    input logic              pad_oe,
    input logic              active,
    input logic              pol_high,
    input logic              push_pull
);
    a_r6_pp_drives: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> pad_oe);

    a_r7_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        !push_pull |-> !pad_out);

    a_r3_key_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[DATA_W-1 -: 8] == 8'hA5) |=> pol_high);

    a_r4_key_pp: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[DATA_W-1 -: 8] == 8'hA8) |=> push_pull);

    a_r5_other_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[DATA_W-1 -: 8] != 8'hA5 && wr_data[DATA_W-1 -: 8] != 8'h5A
               && wr_data[DATA_W-1 -: 8] != 8'hA8 && wr_data[DATA_W-1 -: 8] != 8'h8A)
        |=> ($stable(pol_high) && $stable(push_pull)));

    a_r2_edges_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(active));
endmodule

bind ext_reset_pulser ext_reset_pulser_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .pad_out(pad_out), .pad_oe(pad_oe), .active(pulse_active),
    .pol_high(pol_high), .push_pull(push_pull)
);

// File: tb/test_ext_reset_pulser.sv
module test_ext_reset_pulser;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    typedef struct {
        int len;
        bit pol;
        bit pp;
        string req;
    } pulse_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick;
    logic        trig = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mdl_pol = 0;
    bit mdl_pp = 0;
    pulse_item_t exp_q[$];
    int tick_cnt = 0;

    always #(CLK_PERIOD/2) clk = !clk;

    always_ff @(posedge clk) tick_cnt <= (tick_cnt + 1) % TICK_DIV;
    assign tick = (tick_cnt == TICK_DIV - 1);

    ext_reset_pulser i_ext_reset_pulser (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic bit is_asserted(bit pol, bit pp, logic o, logic oe);
        if (pp) return (o == pol);
        return pol ? !oe : oe;
    endfunction

    function automatic logic [1:0] exp_pins(bit act, bit pol, bit pp);
        bit lvl = pol ? act : !act;
        return pp ? {lvl, 1'b1} : {1'b0, !lvl};
    endfunction

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        case (d[31:24])
            8'hA5: mdl_pol = 1;
            8'h5A: mdl_pol = 0;
            8'hA8: mdl_pp = 1;
            8'h8A: mdl_pp = 0;
            default: ;
        endcase
    endtask

    task automatic rd_check(input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1;
        #1;
        check(rd_data === exp, req, rd_data, exp);
        rd_en = 1'b0;
        #1;
        check(rd_data === 32'h0, "R10", rd_data, 32'h0);
    endtask

    task automatic idle_pin_check(input string req);
        logic [1:0] e;
        @(negedge clk);
        e = exp_pins(0, mdl_pol, mdl_pp);
        check({pad_out, pad_oe} === e, req, {30'd0, pad_out, pad_oe}, {30'd0, e});
    endtask

    task automatic fire(input int n, input string req);
        pulse_item_t it;
        it.len = (n + 1) * TICK_DIV; it.pol = mdl_pol; it.pp = mdl_pp; it.req = req;
        exp_q.push_back(it);
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_drain();
        wait (exp_q.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    // monitor: measures each pulse and compares with the queued expectation
    initial begin
        forever begin
            pulse_item_t it;
            int n;
            bit pins_ok;
            wait (exp_q.size() > 0);
            it = exp_q[0];
            do @(negedge clk); while (!is_asserted(it.pol, it.pp, pad_out, pad_oe));
            n = 0; pins_ok = 1;
            while (is_asserted(it.pol, it.pp, pad_out, pad_oe)) begin
                if ({pad_out, pad_oe} !== exp_pins(1, it.pol, it.pp)) pins_ok = 0;
                n++;
                @(negedge clk);
            end
            check(n == it.len, it.req, n, it.len);
            check(pins_ok, it.pp ? "R6" : "R7", {30'd0, pad_out, pad_oe},
                  {30'd0, exp_pins(1, it.pol, it.pp)});
            void'(exp_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_check(32'h0000_00FF, "R1");
        idle_pin_check("R1");
        // R5 no key, duration still loaded; R2 pulse length
        wr(32'h0000_0002);
        rd_check(32'h0000_0002, "R5");
        fire(2, "R2");
        wait_drain();
        // R3 active-high, open-drain
        wr(32'hA500_0003);
        rd_check(32'h8000_0003, "R3");
        idle_pin_check("R7");
        fire(3, "R2");
        wait_drain();
        // R4 push-pull
        wr(32'hA800_0001);
        rd_check(32'hC000_0001, "R4");
        idle_pin_check("R6");
        fire(1, "R2");
        wait_drain();
        // R3 back to low, minimum length N=0
        wr(32'h5A00_0000);
        rd_check(32'h4000_0000, "R3");
        idle_pin_check("R6");
        fire(0, "R2");
        wait_drain();
        // R4 open-drain
        wr(32'h8A00_0004);
        rd_check(32'h0000_0004, "R4");
        idle_pin_check("R7");
        // R8/R9 retrigger and mid-pulse write
        fire(4, "R9");
        @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
        wr(32'h0000_0001);
        repeat (6) @(negedge clk);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        wait_drain();
        begin
            bit quiet = 1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (is_asserted(mdl_pol, mdl_pp, pad_out, pad_oe)) quiet = 0;
            end
            check(quiet, "R8", {31'd0, !quiet}, 32'd0);
        end
        rd_check(32'h0000_0001, "R9");
        // R10 bits 29:20 ignored; R5 non-key byte near a key
        wr(32'hFFF0_0005);
        rd_check(32'h0000_0005, "R10");
        wr(32'hA5F0_0006);
        wr(32'hA600_0007);
        rd_check(32'h8000_0007, "R5");
        wr(32'hA9FF_FFFF);
        rd_check(32'h800F_FFFF, "R5");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule